// File: doc/BRIEF.md
# Stride-Based Low-Switching Address Bus Codec

This block holds both ends of a long address bus. The transmit side re-encodes each address so that the wires toggle less. The receive side restores the original address. Addresses that advance by a fixed stride, as instruction fetches do, are the case the codes are built for. In that case the bus either keeps its last value or carries a value derived from the previous state.

Four codes are available:
- The first adds a separate "advanced by stride" wire.
- The second reaches the same freeze without the extra wire, using a three-way choice.
- The third XORs the address with its predicted successor and with the previous bus value.
- The fourth XORs the address difference with the previous bus value.

Each side keeps its own copy of the last address and the last bus value. Both sides must be reset together with the same code selected.

Both sides are registered, with one cycle of latency, and both are gated by a valid strobe. When a side is idle it keeps its outputs unchanged. The stride and the address width are parameters. All address arithmetic wraps modulo 2^AW.

Top module: `stride_bus_codec`

## Requirements
- R1: While reset is low, both valid outputs, `enc_bus_o`, `enc_inc_o` and `dec_addr_o` read 0. The first accepted transfer after reset drives the raw address on the bus with the increment wire low, in every code.
- R2: In code 0 (extra wire), a transfer whose address equals the previous address plus STRIDE drives `enc_inc_o` high and leaves `enc_bus_o` at its previous value.
- R3: In code 0, a transfer whose address is not the previous address plus STRIDE drives `enc_inc_o` low and the raw address on the bus. This includes backward jumps.
- R4: In code 1 (no extra wire), the bus value is chosen in this order:
  - the previous bus value, when the address is sequential;
  - otherwise the address itself, when it differs from the previous bus value;
  - otherwise the previous address plus STRIDE.
- R5: In code 2, the bus value is address XOR (previous address + STRIDE) XOR previous bus value.
- R6: In code 3, the bus value is (address - previous address) XOR previous bus value.
- R7: For every accepted transfer, the decoder fed with the encoder outputs presents the original address on `dec_addr_o`, in every code.
- R8: Address arithmetic wraps modulo 2^AW. A step from 2^AW-STRIDE to 0 counts as sequential, and negative differences wrap.
- R9: `mode_sel` is captured only while reset is low (0 = extra wire, 1 = no extra wire, 2 = XOR, 3 = offset XOR). Changing it while out of reset has no effect on the encoding.
- R10: Each side's output valid rises exactly one cycle after its input valid. A cycle with input valid low clears output valid and leaves the output bus or address unchanged.
- R11: `enc_inc_o` is high only in code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset, also the code-capture window |
| mode_sel | input | 2 | Code selection, sampled during reset |
| enc_valid_i | input | 1 | Source address valid |
| enc_addr_i | input | AW | Source address |
| enc_valid_o | output | 1 | Encoded bus word valid |
| enc_bus_o | output | AW | Encoded bus word |
| enc_inc_o | output | 1 | Advanced-by-stride wire (code 0 only) |
| dec_valid_i | input | 1 | Received bus word valid |
| dec_bus_i | input | AW | Received bus word |
| dec_inc_i | input | 1 | Received advanced-by-stride wire |
| dec_valid_o | output | 1 | Recovered address valid |
| dec_addr_o | output | AW | Recovered address |

## Verification
The hardest case to reach is the third branch of code 1. The address is not sequential, yet it equals the value currently frozen on the bus. It can only occur after a sequential step has separated the bus value from the address.

The stimulus sends an address, then its stride successor, which freezes the bus. It then jumps back to the first address. The decoder must then map the unusual bus word back through its stored bus value.

Wrap-around steps at the top of the address space are also sent. So is a mid-run change of `mode_sel`, which must be ignored.

// File: rtl/sbc_pkg.sv
// Shared definitions for the stride-based bus codec.
// Assumes a 2-bit code selector; the encoding values are fixed by the pin contract.
package sbc_pkg;

    typedef enum logic [1:0] {
        CODE_EXTRA_WIRE = 2'd0,
        CODE_NO_WIRE    = 2'd1,
        CODE_XOR        = 2'd2,
        CODE_OFFSET_XOR = 2'd3
    } code_mode_e;

endpackage

// File: rtl/sbc_history.sv
// Per-side history: latched code, last address, last bus word, first-transfer flag.
// Assumes both sides leave reset in the same cycle with the same mode_sel_i.
module sbc_history
    import sbc_pkg::*;
#(
    parameter int AW     = 16,
    parameter int STRIDE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel_i,
    input  logic          upd_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] bus_i,
    output code_mode_e    mode_o,
    output logic          first_o,
    output logic [AW-1:0] prev_addr_o,
    output logic [AW-1:0] prev_bus_o,
    output logic [AW-1:0] next_addr_o
);

    localparam logic [AW-1:0] STEP = AW'(STRIDE);

    code_mode_e    mode_q;
    logic          first_q;
    logic [AW-1:0] addr_q;
    logic [AW-1:0] bus_q;

    // Capture the code only inside the reset window.
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= code_mode_e'(mode_sel_i);
    end

    // Record the last accepted address and bus word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= 1'b1;
            addr_q  <= '0;
            bus_q   <= '0;
        end else if (upd_i) begin
            first_q <= 1'b0;
            addr_q  <= addr_i;
            bus_q   <= bus_i;
        end
    end

    assign mode_o      = mode_q;
    assign first_o     = first_q;
    assign prev_addr_o = addr_q;
    assign prev_bus_o  = bus_q;
    assign next_addr_o = addr_q + STEP;

    // R9: the code cannot move while out of reset.
    a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));

endmodule

// File: rtl/sbc_encoder.sv
// Transmit side: maps each source address to a low-toggle bus word.
// Assumes addresses arrive one per cycle when valid_i is high; outputs are registered.
module sbc_encoder
    import sbc_pkg::*;
#(
    parameter int AW     = 16,
    parameter int STRIDE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel_i,
    input  logic          valid_i,
    input  logic [AW-1:0] addr_i,
    output logic          valid_o,
    output logic [AW-1:0] bus_o,
    output logic          inc_o
);

    code_mode_e    mode;
    logic          first;
    logic [AW-1:0] prev_addr;
    logic [AW-1:0] prev_bus;
    logic [AW-1:0] next_addr;
    logic          seq_hit;
    logic [AW-1:0] bus_n;
    logic          inc_n;

    sbc_history #(.AW(AW), .STRIDE(STRIDE)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel_i (mode_sel_i),
        .upd_i      (valid_i),
        .addr_i     (addr_i),
        .bus_i      (bus_n),
        .mode_o     (mode),
        .first_o    (first),
        .prev_addr_o(prev_addr),
        .prev_bus_o (prev_bus),
        .next_addr_o(next_addr)
    );

    assign seq_hit = (addr_i == next_addr);

    // Select the bus word and increment wire for the latched code.
    always_comb begin
        bus_n = addr_i;
        inc_n = 1'b0;
        if (!first) begin
            unique case (mode)
                CODE_EXTRA_WIRE: begin
                    if (seq_hit) begin
                        bus_n = prev_bus;
                        inc_n = 1'b1;
                    end
                end
                CODE_NO_WIRE: begin
                    if (seq_hit)                  bus_n = prev_bus;
                    else if (addr_i != prev_bus)  bus_n = addr_i;
                    else                          bus_n = next_addr;
                end
                CODE_XOR:        bus_n = addr_i ^ next_addr ^ prev_bus;
                CODE_OFFSET_XOR: bus_n = (addr_i - prev_addr) ^ prev_bus;
                default:         bus_n = addr_i;
            endcase
        end
    end

    // Register the outputs; the bus word holds when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            bus_o   <= '0;
            inc_o   <= 1'b0;
        end else begin
            valid_o <= valid_i;
            inc_o   <= valid_i & inc_n;
            if (valid_i) bus_o <= bus_n;
        end
    end

    // R11: the extra wire is only used by code 0.
    a_r11_inc_only_code0: assert property (@(posedge clk) disable iff (!rst_n)
        inc_o |-> (mode == CODE_EXTRA_WIRE));

    // R2: a sequential address in code 0 freezes the bus and raises the wire.
    a_r2_freeze_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && !first && seq_hit && mode == CODE_EXTRA_WIRE) |=> (inc_o && $stable(bus_o)));

    // R1: the first transfer after reset carries the raw address.
    a_r1_first_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && first) |=> (bus_o == $past(addr_i) && !inc_o));

    // R10: idle cycles clear valid and keep the bus word.
    a_r10_enc_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!valid_o && $stable(bus_o)));

endmodule

// File: rtl/sbc_decoder.sv
// Receive side: restores the source address from the bus word and increment wire.
// Assumes it sees exactly the words the encoder produced, in order, under the same code.
module sbc_decoder
    import sbc_pkg::*;
#(
    parameter int AW     = 16,
    parameter int STRIDE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel_i,
    input  logic          valid_i,
    input  logic [AW-1:0] bus_i,
    input  logic          inc_i,
    output logic          valid_o,
    output logic [AW-1:0] addr_o
);

    code_mode_e    mode;
    logic          first;
    logic [AW-1:0] prev_addr;
    logic [AW-1:0] prev_bus;
    logic [AW-1:0] next_addr;
    logic [AW-1:0] addr_n;

    sbc_history #(.AW(AW), .STRIDE(STRIDE)) u_hist (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel_i (mode_sel_i),
        .upd_i      (valid_i),
        .addr_i     (addr_n),
        .bus_i      (bus_i),
        .mode_o     (mode),
        .first_o    (first),
        .prev_addr_o(prev_addr),
        .prev_bus_o (prev_bus),
        .next_addr_o(next_addr)
    );

    // Invert the latched code.
    always_comb begin
        addr_n = bus_i;
        if (!first) begin
            unique case (mode)
                CODE_EXTRA_WIRE: if (inc_i) addr_n = next_addr;
                CODE_NO_WIRE: begin
                    if (bus_i == prev_bus)       addr_n = next_addr;
                    else if (bus_i == next_addr) addr_n = prev_bus;
                    else                         addr_n = bus_i;
                end
                CODE_XOR:        addr_n = bus_i ^ prev_bus ^ next_addr;
                CODE_OFFSET_XOR: addr_n = (bus_i ^ prev_bus) + prev_addr;
                default:         addr_n = bus_i;
            endcase
        end
    end

    // Register the recovered address; it holds when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            addr_o  <= '0;
        end else begin
            valid_o <= valid_i;
            if (valid_i) addr_o <= addr_n;
        end
    end

    // R3: in code 0 with the wire low, the bus word is the address.
    a_r3_raw_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && mode == CODE_EXTRA_WIRE && !inc_i) |=> (addr_o == $past(bus_i)));

    // R10: one cycle of latency.
    a_r10_dec_latency: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);

    // R10: idle cycles clear valid and keep the address.
    a_r10_dec_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> (!valid_o && $stable(addr_o)));

endmodule

// File: rtl/stride_bus_codec.sv
// Top: independent transmit and receive sides of the stride-based bus codec.
// Assumes the caller wires the encoder outputs to the decoder inputs across the bus.
module stride_bus_codec
    import sbc_pkg::*;
#(
    parameter int AW     = 16,
    parameter int STRIDE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    mode_sel,
    input  logic          enc_valid_i,
    input  logic [AW-1:0] enc_addr_i,
    output logic          enc_valid_o,
    output logic [AW-1:0] enc_bus_o,
    output logic          enc_inc_o,
    input  logic          dec_valid_i,
    input  logic [AW-1:0] dec_bus_i,
    input  logic          dec_inc_i,
    output logic          dec_valid_o,
    output logic [AW-1:0] dec_addr_o
);

    sbc_encoder #(.AW(AW), .STRIDE(STRIDE)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel_i(mode_sel),
        .valid_i   (enc_valid_i),
        .addr_i    (enc_addr_i),
        .valid_o   (enc_valid_o),
        .bus_o     (enc_bus_o),
        .inc_o     (enc_inc_o)
    );

    sbc_decoder #(.AW(AW), .STRIDE(STRIDE)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel_i(mode_sel),
        .valid_i   (dec_valid_i),
        .bus_i     (dec_bus_i),
        .inc_i     (dec_inc_i),
        .valid_o   (dec_valid_o),
        .addr_o    (dec_addr_o)
    );

endmodule

// File: tb/sim_stride_bus_codec.sv
`timescale 1ns/1ps
module sim_stride_bus_codec;

    localparam int AW     = 16;
    localparam int STRIDE = 4;
    localparam logic [AW-1:0] S = AW'(STRIDE);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_sel = 2'd0;
    logic          enc_valid_i = 1'b0;
    logic [AW-1:0] enc_addr_i = '0;
    logic          enc_valid_o;
    logic [AW-1:0] enc_bus_o;
    logic          enc_inc_o;
    logic          dec_valid_o;
    logic [AW-1:0] dec_addr_o;

    always #2.5 clk = ~clk;

    stride_bus_codec #(.AW(AW), .STRIDE(STRIDE)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .enc_valid_i(enc_valid_i),
        .enc_addr_i (enc_addr_i),
        .enc_valid_o(enc_valid_o),
        .enc_bus_o  (enc_bus_o),
        .enc_inc_o  (enc_inc_o),
        .dec_valid_i(enc_valid_o),
        .dec_bus_i  (enc_bus_o),
        .dec_inc_i  (enc_inc_o),
        .dec_valid_o(dec_valid_o),
        .dec_addr_o (dec_addr_o)
    );

    typedef struct {
        logic [AW-1:0] addr;
        logic [AW-1:0] bus;
        logic          inc;
        int            cyc;
        string         req;
    } item_t;

    item_t eq[$];
    item_t dq[$];

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    int            m_mode;
    bit            m_first;
    logic [AW-1:0] m_pa;
    logic [AW-1:0] m_pb;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: pop expected items as each side produces results.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (enc_valid_o) begin
                if (eq.size() == 0) chk(1'b0, "R10", "unexpected enc valid", 1, 0);
                else begin
                    item_t it;
                    it = eq.pop_front();
                    chk(enc_bus_o == it.bus, it.req, "enc bus", enc_bus_o, it.bus);
                    chk(enc_inc_o == it.inc, (m_mode == 0) ? it.req : "R11", "enc inc",
                        AW'(enc_inc_o), AW'(it.inc));
                    chk(cyc == it.cyc + 1, "R10", "enc latency", AW'(cyc), AW'(it.cyc + 1));
                end
            end
            if (dec_valid_o) begin
                if (dq.size() == 0) chk(1'b0, "R10", "unexpected dec valid", 1, 0);
                else begin
                    item_t it;
                    it = dq.pop_front();
                    chk(dec_addr_o == it.addr, "R7", "dec addr", dec_addr_o, it.addr);
                    chk(cyc == it.cyc + 2, "R10", "dec latency", AW'(cyc), AW'(it.cyc + 2));
                end
            end
        end
    end

    // Driver: one transfer, with its expected bus word computed from the requirements.
    task automatic send(input logic [AW-1:0] a, input string req);
        item_t it;
        logic [AW-1:0] nx;
        logic [AW-1:0] eb;
        logic ei;
        @(negedge clk);
        enc_valid_i = 1'b1;
        enc_addr_i  = a;
        nx = m_pa + S;
        eb = a;
        ei = 1'b0;
        if (!m_first) begin
            case (m_mode)
                0: if (a == nx) begin eb = m_pb; ei = 1'b1; end
                1: begin
                    if (a == nx)        eb = m_pb;
                    else if (a != m_pb) eb = a;
                    else                eb = nx;
                end
                2: eb = a ^ nx ^ m_pb;
                default: eb = (a - m_pa) ^ m_pb;
            endcase
        end
        it.addr = a; it.bus = eb; it.inc = ei; it.cyc = cyc; it.req = req;
        eq.push_back(it);
        dq.push_back(it);
        m_pa = a; m_pb = eb; m_first = 1'b0;
    endtask

    // Idle cycles: valid low, bus word must hold (R10).
    task automatic idle(input int n);
        logic [AW-1:0] held;
        @(negedge clk);
        enc_valid_i = 1'b0;
        held = enc_bus_o;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(!enc_valid_o, "R10", "enc valid idle", AW'(enc_valid_o), 0);
            chk(enc_bus_o == held, "R10", "bus hold idle", enc_bus_o, held);
        end
    endtask

    task automatic do_reset(input int mode);
        @(negedge clk);
        rst_n = 1'b0;
        enc_valid_i = 1'b0;
        mode_sel = 2'(mode);
        repeat (3) @(negedge clk);
        chk(!enc_valid_o, "R1", "enc valid reset", AW'(enc_valid_o), 0);
        chk(!dec_valid_o, "R1", "dec valid reset", AW'(dec_valid_o), 0);
        chk(enc_bus_o == '0, "R1", "bus reset", enc_bus_o, 0);
        chk(!enc_inc_o, "R1", "inc reset", AW'(enc_inc_o), 0);
        chk(dec_addr_o == '0, "R1", "dec addr reset", dec_addr_o, 0);
        eq.delete(); dq.delete();
        m_mode = mode; m_first = 1'b1; m_pa = '0; m_pb = '0;
        rst_n = 1'b1;
    endtask

    initial begin
        // Code 0: extra wire.
        do_reset(0);
        send(16'h1000, "R1");
        send(16'h1004, "R2");
        send(16'h1008, "R2");
        send(16'h2000, "R3");
        send(16'h0FF0, "R3");
        idle(3);
        send(16'h0FF4, "R2");
        send(16'hFFF8, "R3");
        send(16'hFFFC, "R2");
        send(16'h0000, "R8");
        idle(3);

        // Code 1: no extra wire, including the address-equals-frozen-bus branch.
        do_reset(1);
        send(16'h0100, "R1");
        send(16'h0104, "R4");
        send(16'h0100, "R4");
        send(16'h0200, "R4");
        send(16'h0204, "R4");
        send(16'h0200, "R4");
        send(16'hFFFC, "R4");
        send(16'h0000, "R8");
        idle(3);

        // Code 2: XOR, with an ignored mode_sel change (R9).
        do_reset(2);
        send(16'h0040, "R1");
        send(16'h0044, "R5");
        send(16'h0048, "R5");
        send(16'h1234, "R5");
        send(16'h0010, "R5");
        mode_sel = 2'd0;
        send(16'h5555, "R9");
        send(16'h0ABC, "R9");
        idle(3);

        // Code 3: offset XOR, with negative differences.
        do_reset(3);
        send(16'h0010, "R1");
        send(16'h0004, "R8");
        send(16'h0008, "R6");
        send(16'h8000, "R6");
        send(16'h7FFC, "R6");
        idle(3);

        chk(eq.size() == 0 && dq.size() == 0, "R7", "queues drained",
            AW'(eq.size() + dq.size()), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (!done && cyc > 5000) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog actual=%0d expected<=5000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule